// File: doc/BRIEF.md
# Dual-Space I2C Slave Controller

This block is an I2C target that answers to two 7-bit device IDs. One ID opens a byte-wide memory space that takes a 16-bit address. The other ID opens a small companion register space that takes an 8-bit address. Each space has its own address pointer. A transfer to one space never moves the pointer of the other, so an interrupted memory read can resume later at the place it stopped.

SCL and SDA arrive already synchronised to `clk`. The block pulls SDA low by raising `sda_oe`, and the pad logic outside the block provides the open-drain driver. Storage sits outside the block and is reached through simple synchronous ports:

- `mem_addr` and `reg_addr` carry the two pointers.
- A one-cycle write strobe and the shared `wr_data` bus perform writes.
- Read data is expected one clock after the address, as from a block RAM.

Top module: `dsi2c_slave`

## Requirements
- R1: The block acknowledges a device byte whose upper 7 bits equal MEM_ID or REG_ID (bit 0 is R/W, 1 = read). It does not acknowledge any other ID. After an unmatched ID it drives nothing and writes nothing until the next start condition.
- R2: A memory write is made of the device byte with R/W=0, then the address high byte, then the address low byte, then data bytes. Each data byte is stored at consecutive memory addresses. Every byte is acknowledged.
- R3: A register write is made of the device byte with R/W=0, then a single address byte, then data bytes. Each data byte is stored at consecutive register addresses. Every byte is acknowledged.
- R4: The memory pointer and the register pointer are independent. Any access to one space leaves the other space's pointer unchanged.
- R5: A read (device byte with R/W=1) takes no address bytes. Its first data bit is driven on the SCL fall that ends the acknowledge, from the selected space's current pointer.
- R6: An address write followed by a repeated start stores no data. The read that follows starts at the newly loaded address.
- R7: The pointer advances after every byte written or read. The memory pointer wraps from MEM_DEPTH-1 to 0, and the register pointer wraps from REG_COUNT-1 to 0.
- R8: In a read, a master ACK (SDA low in the ninth bit) fetches the next byte. A master NACK makes the block release SDA, and it stays released through the stop.
- R9: SDA is released after a stop and changes only while SCL is low. Write strobes last one clock and never occur in both spaces at once.
- R10: After reset, `sda_oe` and both strobes are low and both pointers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired bus) |
| sda_oe | output | 1 | 1 pulls SDA low |
| mem_addr | output | 16 | Memory space pointer |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read data, one clock after address |
| reg_addr | output | 8 | Register space pointer |
| reg_we | output | 1 | Register write strobe |
| reg_rdata | input | 8 | Register read data, one clock after address |
| wr_data | output | 8 | Write data for either space |

## Verification
The bench checks the bus-level result of each transfer and the storage contents after it:

- A wrong pointer is not visible at once. It first shows as the wrong data byte on the next read of that space, or as a store to the wrong location that the final storage compare reports. Because of that delay, every random transfer is checked against a bench model of both pointers.
- A state machine that loses its bit count shows within one byte, as a missing acknowledge or SDA held low in the ninth bit.
- An error in ID matching shows as a strobe during an ignored transfer.

// File: rtl/dsi2c_pkg.sv
package dsi2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK, ST_SKIP
  } bus_st_t;

  typedef enum logic [1:0] {
    PH_DEV, PH_AHI, PH_ALO, PH_DATA
  } rx_ph_t;
endpackage

// File: rtl/dsi2c_cond.sv
module dsi2c_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/dsi2c_ptr.sv
module dsi2c_ptr #(
  parameter int W     = 16,
  parameter int COUNT = 1024
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] ptr
);
  localparam logic [W-1:0] LAST = W'(COUNT - 1);

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= (ptr == LAST) ? '0 : ptr + W'(1);
  end
endmodule

// File: rtl/dsi2c_slave.sv
module dsi2c_slave #(
  parameter logic [6:0] MEM_ID    = 7'h50,
  parameter logic [6:0] REG_ID    = 7'h68,
  parameter int         MEM_DEPTH = 1024,
  parameter int         REG_COUNT = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  reg_addr,
  output logic        reg_we,
  input  logic [7:0]  reg_rdata,
  output logic [7:0]  wr_data
);
  import dsi2c_pkg::*;

  localparam int MAW = 16;
  localparam int RAW = 8;

  logic scl_rise, scl_fall, start_c, stop_c;
  bus_st_t st;
  rx_ph_t  ph;
  logic [3:0] cnt;
  logic [7:0] sh, txsh, ahi;
  logic sel_mem, rd_mode, m_ack, rd_inc_q;
  logic ld_mem_q, ld_reg_q;
  logic [MAW-1:0] ld_val_q;
  logic [MAW-1:0] mem_ptr;
  logic [RAW-1:0] reg_ptr;
  logic [7:0] rdsel;
  logic is_mem_id, is_reg_id;

  dsi2c_cond u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  dsi2c_ptr #(.W(MAW), .COUNT(MEM_DEPTH)) u_mem_ptr (
    .clk(clk), .rst(rst), .load(ld_mem_q), .load_val(ld_val_q),
    .inc(mem_we | (rd_inc_q & sel_mem)), .ptr(mem_ptr)
  );

  dsi2c_ptr #(.W(RAW), .COUNT(REG_COUNT)) u_reg_ptr (
    .clk(clk), .rst(rst), .load(ld_reg_q), .load_val(ld_val_q[RAW-1:0]),
    .inc(reg_we | (rd_inc_q & ~sel_mem)), .ptr(reg_ptr)
  );

  assign rdsel     = sel_mem ? mem_rdata : reg_rdata;
  assign is_mem_id = (sh[7:1] == MEM_ID);
  assign is_reg_id = (sh[7:1] == REG_ID);
  assign mem_addr  = mem_ptr;
  assign reg_addr  = reg_ptr;

  always_ff @(posedge clk) begin
    mem_we   <= 1'b0;
    reg_we   <= 1'b0;
    rd_inc_q <= 1'b0;
    ld_mem_q <= 1'b0;
    ld_reg_q <= 1'b0;
    if (rst) begin
      st       <= ST_IDLE;
      ph       <= PH_DEV;
      cnt      <= '0;
      sh       <= '0;
      txsh     <= '0;
      ahi      <= '0;
      sel_mem  <= 1'b0;
      rd_mode  <= 1'b0;
      m_ack    <= 1'b0;
      sda_oe   <= 1'b0;
      wr_data  <= '0;
      ld_val_q <= '0;
    end else if (start_c) begin
      st     <= ST_RX;
      ph     <= PH_DEV;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_i};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            case (ph)
              PH_DEV: begin
                if (is_mem_id || is_reg_id) begin
                  sel_mem <= is_mem_id;
                  rd_mode <= sh[0];
                  ph      <= is_mem_id ? PH_AHI : PH_ALO;
                  sda_oe  <= 1'b1;
                  st      <= ST_ACK;
                end else begin
                  st <= ST_SKIP;
                end
              end
              PH_AHI: begin
                ahi    <= sh;
                ph     <= PH_ALO;
                sda_oe <= 1'b1;
                st     <= ST_ACK;
              end
              PH_ALO: begin
                ld_val_q <= sel_mem ? {ahi, sh} : {8'h00, sh};
                ld_mem_q <= sel_mem;
                ld_reg_q <= ~sel_mem;
                ph       <= PH_DATA;
                sda_oe   <= 1'b1;
                st       <= ST_ACK;
              end
              default: begin
                wr_data <= sh;
                mem_we  <= sel_mem;
                reg_we  <= ~sel_mem;
                sda_oe  <= 1'b1;
                st      <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rd_mode) begin
              txsh   <= rdsel;
              sda_oe <= ~rdsel[7];
              st     <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe   <= 1'b0;
              rd_inc_q <= 1'b1;
              st       <= ST_MACK;
            end else begin
              txsh   <= {txsh[6:0], 1'b0};
              sda_oe <= ~txsh[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_i;
          end else if (scl_fall) begin
            if (m_ack) begin
              txsh   <= rdsel;
              sda_oe <= ~rdsel[7];
              cnt    <= '0;
              st     <= ST_TX;
            end else begin
              st <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dsi2c_chk.sv
module dsi2c_chk #(
  parameter int MEM_DEPTH = 1024,
  parameter int REG_COUNT = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        scl_i,
  input logic        sda_i,
  input logic        sda_oe,
  input logic        mem_we,
  input logic        reg_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  reg_addr
);
  a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_i));

  a_r9_stop_release: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_oe);

  a_r9_mem_we_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  a_r9_reg_we_pulse: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  a_r9_we_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && reg_we));

  a_r7_mem_range: assert property (@(posedge clk) disable iff (rst)
    32'(mem_addr) < MEM_DEPTH);

  a_r7_reg_range: assert property (@(posedge clk) disable iff (rst)
    32'(reg_addr) < REG_COUNT);

  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (mem_addr == 16'd0 && reg_addr == 8'd0 && !sda_oe && !mem_we && !reg_we));
endmodule

bind dsi2c_slave dsi2c_chk #(.MEM_DEPTH(MEM_DEPTH), .REG_COUNT(REG_COUNT)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
  .mem_we(mem_we), .reg_we(reg_we), .mem_addr(mem_addr), .reg_addr(reg_addr)
);

// File: tb/tb_dsi2c_slave.sv
`timescale 1ns/1ps
module tb_dsi2c_slave;
  localparam int MD = 1024;
  localparam int RC = 16;
  localparam int HW = 8;
  localparam logic [6:0] MID = 7'h50;
  localparam logic [6:0] RID = 7'h68;

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_we, reg_we;
  logic [15:0] mem_addr;
  logic [7:0] reg_addr, wr_data;
  logic [7:0] mem_rdata, reg_rdata;
  wire sda = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  dsi2c_slave #(.MEM_ID(MID), .REG_ID(RID), .MEM_DEPTH(MD), .REG_COUNT(RC)) dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_rdata(mem_rdata),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .wr_data(wr_data)
  );

  logic [7:0] mem_s [MD];
  logic [7:0] reg_s [RC];
  logic [7:0] exp_mem [MD];
  logic [7:0] exp_reg [RC];
  int exp_mp = 0, exp_rp = 0;
  int we_cnt = 0;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (mem_we) mem_s[mem_addr] <= wr_data;
    if (reg_we) reg_s[reg_addr] <= wr_data;
    mem_rdata <= mem_s[mem_addr];
    reg_rdata <= reg_s[reg_addr];
    if (mem_we || reg_we) we_cnt <= we_cnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int nxt(input bit sp, input int p);
    if (sp) return (p == MD - 1) ? 0 : p + 1;
    return (p == RC - 1) ? 0 : p + 1;
  endfunction

  task automatic hw();
    repeat (HW) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; hw(); scl = 1'b1; hw(); sda_m = 1'b0; hw(); scl = 1'b0; hw();
  endtask

  task automatic bstop();
    sda_m = 1'b0; hw(); scl = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hw(); scl = 1'b1; hw(); scl = 1'b0;
    end
    sda_m = 1'b1; hw(); scl = 1'b1; hw();
    ack = ~sda;
    scl = 1'b0; hw();
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      hw(); scl = 1'b1; hw();
      b = {b[6:0], sda};
      scl = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1;
    hw(); scl = 1'b1; hw(); scl = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic send_addr(input bit sp, input int a);
    logic ack;
    wbyte({sp ? MID : RID, 1'b0}, ack); chk("R1 id ack", ack, 1);
    if (sp) begin
      wbyte(8'(a >> 8), ack); chk("R2 addr hi ack", ack, 1);
      wbyte(8'(a), ack);      chk("R2 addr lo ack", ack, 1);
      exp_mp = a;
    end else begin
      wbyte(8'(a), ack);      chk("R3 addr ack", ack, 1);
      exp_rp = a;
    end
  endtask

  task automatic xwrite(input bit sp, input int a, input int n);
    logic ack;
    logic [7:0] d;
    bstart();
    send_addr(sp, a);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      wbyte(d, ack);
      chk(sp ? "R2 data ack" : "R3 data ack", ack, 1);
      if (sp) begin exp_mem[exp_mp] = d; exp_mp = nxt(1, exp_mp); end
      else    begin exp_reg[exp_rp] = d; exp_rp = nxt(0, exp_rp); end
    end
    bstop();
  endtask

  task automatic read_body(input bit sp, input int n, input string tag);
    logic ack;
    logic [7:0] b;
    wbyte({sp ? MID : RID, 1'b1}, ack); chk("R1 read id ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(k != n - 1, b);
      if (sp) begin chk(tag, b, exp_mem[exp_mp]); exp_mp = nxt(1, exp_mp); end
      else    begin chk(tag, b, exp_reg[exp_rp]); exp_rp = nxt(0, exp_rp); end
    end
    bstop();
    chk("R8 sda released after nack/stop", sda_oe, 0);
  endtask

  task automatic xread_cur(input bit sp, input int n);
    bstart();
    read_body(sp, n, "R5 current read data");
  endtask

  task automatic xread_sel(input bit sp, input int a, input int n);
    bstart();
    send_addr(sp, a);
    bstart();
    read_body(sp, n, "R6 selective read data");
  endtask

  initial begin
    logic ack;
    int w0;
    void'($urandom(32'd1234));
    for (int i = 0; i < MD; i++) begin mem_s[i] = 8'($urandom); exp_mem[i] = mem_s[i]; end
    for (int i = 0; i < RC; i++) begin reg_s[i] = 8'($urandom); exp_reg[i] = reg_s[i]; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 sda_oe after reset", sda_oe, 0);
    chk("R10 mem_we after reset", mem_we, 0);
    chk("R10 reg_we after reset", reg_we, 0);
    chk("R10 mem ptr after reset", mem_addr, 0);
    chk("R10 reg ptr after reset", reg_addr, 0);
    xread_cur(1, 1);

    xwrite(1, 16'h123, 3);
    xread_sel(1, 16'h123, 3);
    xwrite(0, 5, 2);
    chk("R4 mem ptr kept", mem_addr, exp_mp);
    xread_cur(1, 2);
    xread_cur(0, 1);

    xwrite(1, MD - 1, 2);
    chk("R7 mem wrap store", mem_s[0], exp_mem[0]);
    xread_sel(0, RC - 1, 3);
    chk("R7 reg ptr wrapped", reg_addr, exp_rp);

    w0 = we_cnt;
    bstart();
    wbyte({7'h11, 1'b0}, ack); chk("R1 foreign id nack", ack, 0);
    wbyte(8'h00, ack);         chk("R1 ignored byte nack", ack, 0);
    wbyte(8'h5a, ack);         chk("R1 ignored data nack", ack, 0);
    bstop();
    chk("R1 no write after foreign id", we_cnt, w0);
    xread_cur(1, 1);

    w0 = we_cnt;
    bstart();
    send_addr(1, 16'h40);
    bstart();
    read_body(1, 1, "R6 read after restart");
    chk("R6 restart stores nothing", we_cnt, w0);

    for (int t = 0; t < 45; t++) begin
      int op, sp, n, a;
      op = $urandom_range(0, 2);
      sp = $urandom_range(0, 1);
      n  = $urandom_range(0, 4);
      a  = sp ? $urandom_range(0, MD - 1) : $urandom_range(0, RC - 1);
      case (op)
        0: xwrite(sp[0], a, n);
        1: xread_cur(sp[0], n + 1);
        default: xread_sel(sp[0], a, n + 1);
      endcase
    end

    for (int i = 0; i < MD; i++) if (mem_s[i] !== exp_mem[i]) chk("R2 memory contents", mem_s[i], exp_mem[i]);
    for (int i = 0; i < RC; i++) if (reg_s[i] !== exp_reg[i]) chk("R3 register contents", reg_s[i], exp_reg[i]);
    chk("R4 final mem ptr", mem_addr, exp_mp);
    chk("R4 final reg ptr", reg_addr, exp_rp);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule